// File: doc/BRIEF.md
# I2C Receive-Only Slave with Read-Cleared Status

This block is an I2C slave that only ever receives. The SCL and SDA lines come in, pass through a synchroniser, and are watched for START and STOP. The block compares the first byte, or the first two bytes when ten-bit mode is on, against a programmed own address. It acknowledges a matching address and then every data byte that follows. On the bus side it has two pull-down outputs, one for SDA and one for SCL, each of which drives its wire low when high.

Software sees a 4-bit status word and an 8-bit data word. Both are always visible. A one-cycle read strobe for each word marks the read, and the read's side effects clear the flags. A byte that arrives while the holding register is empty never stalls the bus. The block holds SCL low only when a second complete byte lands while the first is still unread. The second byte waits in the shift register until the data word is read.

Top module: `i2c_slave_rx`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Out of reset, and after an address it does not take, the block drives neither line and ignores all traffic until the next START.
- R2: In seven-bit mode, a first byte equal to {own_addr_i[6:0], 0} is acknowledged and sets status bit 0 (address matched). A byte with a different address, or with the read bit set, gets no acknowledge and sets no flag.
- R3: In ten-bit mode, a header 11110, own_addr_i[9:8], 0 is acknowledged. It is followed by a byte equal to own_addr_i[7:0], which is also acknowledged. Status bit 0 is set only after the second byte matches. A mismatching second byte gets no acknowledge.
- R4: A status read strobe clears status bit 0 and status bit 3 on the cycle after the strobe.
- R5: A data byte received while status bit 1 (data ready) is clear appears on data_o and sets bit 1. SCL is not stretched.
- R6: A data byte completed while bit 1 is set sets status bit 2 (buffer full). data_o keeps the first byte, and SCL is held low from the next SCL fall until a data read.
- R7: A data read while bit 2 is set moves the stalled byte to data_o, clears bit 2, keeps bit 1 set and releases SCL.
- R8: A data read while bit 2 is clear clears bit 1.
- R9: A STOP that ends a transfer addressed to this block sets status bit 3. A STOP after an unmatched address does not.
- R10: Every data byte taken is acknowledged by SDA pulled low for the whole ninth SCL clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| own_addr_i | input | 10 | Own slave address (bits 6:0 used in seven-bit mode) |
| ten_bit_i | input | 1 | 1 selects ten-bit addressing |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| scl_pull_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| rd_status_i | input | 1 | Status read strobe, one cycle |
| rd_data_i | input | 1 | Data read strobe, one cycle |
| status_o | output | 4 | {stop seen, buffer full, data ready, address matched} |
| data_o | output | 8 | Holding register |

## Verification
The bench targets the following corner cases, and states what a faulty design would do in each:
- **Two-byte overrun.** A design that stalls on the first byte would freeze SCL during plain traffic. A design that drops the second byte, or overwrites the holding register, would return the wrong value after the release.
- **Ten-bit address flag timing.** A design that raises the match flag on the header alone would show the flag early. The same fault would also accept a transfer whose second address byte differs.
- **Unmatched address.** A design that keeps listening after an unmatched address would acknowledge later bytes. It would also raise the stop flag on a transfer that was never meant for it.
- **Read bit set on the address.** The address byte is sent with its read bit set, and the bench checks that it gets no acknowledge.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR_HI, ST_ADDR_LO, ST_DATA, ST_SKIP
  } rx_state_e;

  // bit order is visible to software: {stop, full, ready, addr}
  typedef struct packed {
    logic stop;
    logic full;
    logic ready;
    logic addr;
  } rx_flags_t;
endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
  import i2c_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ten_bit_i,
  output logic              sda_pull_o,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              addr_hit_o,
  output logic              stop_hit_o
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shift_q, byte_nx, hdr, addr7;
  logic              ack_q, sda_pull_q;
  logic              active;

  assign byte_nx = {shift_q[BYTE_W-2:0], sda_s_i};
  assign hdr     = {5'b11110, own_addr_i[9:8], 1'b0};
  assign addr7   = {own_addr_i[6:0], 1'b0};
  assign active  = (state_q == ST_ADDR_HI) || (state_q == ST_ADDR_LO) || (state_q == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      shift_q     <= '0;
      ack_q       <= 1'b0;
      sda_pull_q  <= 1'b0;
      byte_done_o <= 1'b0;
      addr_hit_o  <= 1'b0;
      stop_hit_o  <= 1'b0;
    end else begin
      byte_done_o <= 1'b0;
      addr_hit_o  <= 1'b0;
      stop_hit_o  <= 1'b0;
      if (start_i) begin
        state_q    <= ST_ADDR_HI;
        cnt_q      <= '0;
        ack_q      <= 1'b0;
        sda_pull_q <= 1'b0;
      end else if (stop_i) begin
        stop_hit_o <= (state_q == ST_DATA);
        state_q    <= ST_IDLE;
        sda_pull_q <= 1'b0;
      end else if (active) begin
        if (scl_rise_i) begin
          if (cnt_q == ACK_SLOT) begin
            cnt_q <= '0;
          end else begin
            shift_q <= byte_nx;
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              ack_q <= 1'b0;
              case (state_q)
                ST_ADDR_HI: begin
                  if (ten_bit_i ? (byte_nx == hdr) : (byte_nx == addr7)) begin
                    ack_q <= 1'b1;
                    if (ten_bit_i) state_q <= ST_ADDR_LO;
                    else begin
                      state_q    <= ST_DATA;
                      addr_hit_o <= 1'b1;
                    end
                  end else begin
                    state_q <= ST_SKIP;
                  end
                end
                ST_ADDR_LO: begin
                  if (byte_nx == own_addr_i[7:0]) begin
                    ack_q      <= 1'b1;
                    state_q    <= ST_DATA;
                    addr_hit_o <= 1'b1;
                  end else begin
                    state_q <= ST_SKIP;
                  end
                end
                ST_DATA: begin
                  ack_q       <= 1'b1;
                  byte_done_o <= 1'b1;
                end
                default: ;
              endcase
            end
          end
        end else if (scl_fall_i) begin
          sda_pull_q <= (cnt_q == ACK_SLOT) && ack_q;
        end
      end else begin
        sda_pull_q <= 1'b0;
      end
    end
  end

  assign sda_pull_o = sda_pull_q;
  assign byte_o     = shift_q;

  // ack must only start while SCL is low
  assert_ack_on_low_scl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_q) |-> !scl_s_i);
  // an unmatched address never produces an acknowledge
  assert_skip_silent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP) |-> !sda_pull_q);
endmodule

// File: rtl/i2c_rx_regs.sv
module i2c_rx_regs
  import i2c_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              addr_hit_i,
  input  logic              stop_hit_i,
  input  logic              scl_fall_i,
  input  logic              rd_status_i,
  input  logic              rd_data_i,
  output rx_flags_t         flags_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              scl_pull_o
);
  rx_flags_t         flags_q;
  logic [BYTE_W-1:0] hold_q;
  logic              stretch_q;
  logic              ready_left;

  // ready as it stands once this cycle's data read has taken effect
  assign ready_left = flags_q.ready & ~(rd_data_i & ~flags_q.full);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q   <= '0;
      hold_q    <= '0;
      stretch_q <= 1'b0;
    end else begin
      if (rd_status_i) begin
        flags_q.addr <= 1'b0;
        flags_q.stop <= 1'b0;
      end
      if (addr_hit_i) flags_q.addr <= 1'b1;
      if (stop_hit_i) flags_q.stop <= 1'b1;

      if (rd_data_i) begin
        if (flags_q.full) begin
          hold_q       <= byte_i;
          flags_q.full <= 1'b0;
        end else begin
          flags_q.ready <= 1'b0;
        end
      end
      if (byte_done_i) begin
        if (!ready_left) begin
          hold_q        <= byte_i;
          flags_q.ready <= 1'b1;
        end else begin
          flags_q.full <= 1'b1;
        end
      end

      if (!flags_q.full || rd_data_i) stretch_q <= 1'b0;
      else if (scl_fall_i)            stretch_q <= 1'b1;
    end
  end

  assign flags_o    = flags_q;
  assign data_o     = hold_q;
  assign scl_pull_o = stretch_q;

  assert_full_has_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q.full |-> flags_q.ready);
  assert_release_on_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && flags_q.full) |=> (!scl_pull_o && flags_q.ready && !flags_q.full));
  assert_status_read_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_status_i && !addr_hit_i && !stop_hit_i) |=> (!flags_q.addr && !flags_q.stop));
  assert_data_read_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && !flags_q.full && !byte_done_i) |=> !flags_q.ready);
  assert_first_byte_no_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && !flags_q.ready) |=> (flags_q.ready && !flags_q.full));
  assert_stop_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_hit_i |=> flags_q.stop);
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ten_bit_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic              rd_status_i,
  input  logic              rd_data_i,
  output logic [3:0]        status_o,
  output logic [BYTE_W-1:0] data_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic byte_done, addr_hit, stop_hit;
  logic [BYTE_W-1:0] rx_byte;
  rx_flags_t flags;

  i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_rx_fsm u_fsm (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
    .own_addr_i, .ten_bit_i, .sda_pull_o,
    .byte_done_o(byte_done), .byte_o(rx_byte), .addr_hit_o(addr_hit), .stop_hit_o(stop_hit)
  );

  i2c_rx_regs u_regs (
    .clk_i, .rst_ni, .byte_done_i(byte_done), .byte_i(rx_byte),
    .addr_hit_i(addr_hit), .stop_hit_i(stop_hit), .scl_fall_i(scl_fall),
    .rd_status_i, .rd_data_i, .flags_o(flags), .data_o, .scl_pull_o
  );

  assign status_o = flags;
endmodule

// File: tb/i2c_slave_rx_tb_top.sv
module i2c_slave_rx_tb_top;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [9:0] own = 10'h05A;
  logic ten = 1'b0;
  logic rd_st = 1'b0, rd_dt = 1'b0;
  logic scl_pull, sda_pull;
  logic [3:0] status;
  logic [7:0] data;
  wire scl_line = m_scl & ~scl_pull;
  wire sda_line = m_sda & ~sda_pull;

  i2c_slave_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .own_addr_i(own), .ten_bit_i(ten),
    .scl_i(scl_line), .sda_i(sda_line), .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
    .rd_status_i(rd_st), .rd_data_i(rd_dt), .status_o(status), .data_o(data)
  );

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic mon_en = 1'b0;
  logic stretched = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wait_scl_high();
    do @(posedge clk); while (!scl_line);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; wait_clk(H);
    m_sda = 1'b0; wait_clk(H);
    m_scl = 1'b0; wait_clk(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_clk(H);
    m_scl = 1'b1; wait_scl_high(); wait_clk(H);
    m_sda = 1'b1; wait_clk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_clk(H);
      m_scl = 1'b1; wait_scl_high(); wait_clk(H);
      m_scl = 1'b0; wait_clk(H);
    end
    m_sda = 1'b1; wait_clk(H);
    m_scl = 1'b1; wait_scl_high(); wait_clk(H/2);
    @(negedge clk) ack = !sda_line;
    wait_clk(H/2);
    m_scl = 1'b0; wait_clk(H);
  endtask

  // driver: expected byte into the scoreboard, then onto the bus
  task automatic send_data(input logic [7:0] b);
    bit ack;
    exp_q.push_back(b);
    send_byte(b, ack);
    chk("R10 data byte acknowledged", ack, 1);
  endtask

  task automatic rd_status_pulse();
    @(negedge clk) rd_st = 1'b1;
    @(negedge clk) rd_st = 1'b0;
  endtask

  task automatic rd_data_pulse();
    @(negedge clk) rd_dt = 1'b1;
    @(negedge clk) rd_dt = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // monitor: drains the holding register and compares against the queue
  initial begin
    logic [7:0] e;
    forever begin
      @(negedge clk);
      if (mon_en && scl_pull) stretched = 1'b1;
      if (mon_en && status[1]) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 unexpected byte actual=0x%0h expected=none", data);
        end else begin
          e = exp_q.pop_front();
          chk("R5 received byte", data, e);
        end
        rd_dt = 1'b1;
        @(negedge clk) rd_dt = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    bit ack, ack2;
    wait_clk(5);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", status, 0);
    chk("R1 reset SDA released", sda_pull, 0);
    chk("R1 reset SCL released", scl_pull, 0);

    // unmatched seven-bit address, then traffic must be ignored
    bus_start();
    send_byte(8'h46, ack);
    chk("R2 wrong address not acked", ack, 0);
    send_byte(8'h11, ack);
    chk("R1 ignored until START", ack, 0);
    @(negedge clk) chk("R2 no flag on mismatch", status, 0);
    bus_stop();
    @(negedge clk) chk("R9 no stop flag when unaddressed", status, 0);

    // read bit set: not a receive transfer
    bus_start();
    send_byte(8'hB5, ack);
    chk("R2 read bit not acked", ack, 0);
    bus_stop();

    // matched seven-bit transfer through the scoreboard
    bus_start();
    send_byte(8'hB4, ack);
    chk("R2 own address acked", ack, 1);
    @(negedge clk) chk("R2 address flag set", status[0], 1);
    rd_status_pulse();
    @(negedge clk) chk("R4 status read clears address flag", status[0], 0);
    stretched = 1'b0;
    mon_en = 1'b1;
    send_data(8'hA5);
    send_data(8'h3C);
    send_data(8'hFF);
    wait_clk(20);
    chk("R5 all bytes delivered", exp_q.size(), 0);
    chk("R5 no stretch when drained", stretched, 0);
    mon_en = 1'b0;
    bus_stop();
    @(negedge clk) chk("R9 stop flag set", status[3], 1);
    rd_status_pulse();
    @(negedge clk) chk("R4 status read clears stop flag", status[3], 0);

    // overrun: second byte while the first is unread
    bus_start();
    send_byte(8'hB4, ack);
    rd_status_pulse();
    send_byte(8'h81, ack);
    chk("R10 first byte acked", ack, 1);
    @(negedge clk);
    chk("R5 single byte: ready only", status, 4'b0010);
    chk("R5 single byte: no stretch", scl_pull, 0);
    chk("R5 single byte on data_o", data, 8'h81);
    fork
      send_byte(8'h7E, ack2);
      begin
        wait (scl_pull === 1'b1);
        wait_clk(4);
        @(negedge clk);
        chk("R6 full and ready set", status[2:1], 2'b11);
        chk("R6 data_o keeps first byte", data, 8'h81);
        wait_clk(200);
        @(negedge clk) chk("R6 SCL held low", scl_line, 0);
        rd_data_pulse();
        @(negedge clk);
        chk("R7 stalled byte moved to data_o", data, 8'h7E);
        chk("R7 full clears, ready stays", status[2:1], 2'b01);
        chk("R7 SCL released", scl_pull, 0);
      end
    join
    chk("R10 stalled byte acked after release", ack2, 1);
    rd_data_pulse();
    @(negedge clk) chk("R8 data read clears ready", status[1], 0);
    bus_stop();
    rd_status_pulse();

    // ten-bit addressing
    ten = 1'b1;
    own = 10'h2B7;
    bus_start();
    send_byte(8'hF4, ack);
    chk("R3 header acked", ack, 1);
    @(negedge clk) chk("R3 no flag after header alone", status[0], 0);
    send_byte(8'hB7, ack);
    chk("R3 low address acked", ack, 1);
    @(negedge clk) chk("R3 flag after second byte", status[0], 1);
    rd_status_pulse();
    mon_en = 1'b1;
    send_data(8'h42);
    wait_clk(20);
    chk("R5 ten-bit byte delivered", exp_q.size(), 0);
    mon_en = 1'b0;
    bus_stop();
    @(negedge clk) chk("R9 stop flag in ten-bit mode", status[3], 1);
    rd_status_pulse();

    bus_start();
    send_byte(8'hF4, ack);
    send_byte(8'hB6, ack);
    chk("R3 wrong low byte not acked", ack, 0);
    @(negedge clk) chk("R3 no flag on low-byte mismatch", status[0], 0);
    bus_stop();
    @(negedge clk) chk("R9 no stop flag after mismatch", status, 0);

    summary();
    $finish;
  end
endmodule